// File: doc/BRIEF.md
# Random Word Generator Peripheral

This block is a memory-mapped random word source for a processor bus. A 32-bit linear feedback shift register stands in for an entropy source. While generation is enabled it yields one bit per clock. The block packs these bits into 32-bit words and queues the words in a 16-entry FIFO. Software reads the words one at a time through a data register.

Before enabling, software loads a warm-up count by writing the status register. Bits produced while that count is nonzero are thrown away, so early output never reaches the FIFO. A read of the status register returns the number of queued words in its top byte. Software polls until that count is nonzero and then pops no more words than it reported. An interrupt line signals that words are waiting, and a mask bit can suppress it.

The bus is a simple single-cycle interface. A write takes effect at the clock edge. Read data is combinational from the address while select is high and write is low. A data-register pop takes effect at that same edge.

Top module: `rng_periph`

## Requirements
- R1: After reset every mapped register reads zero, the FIFO is empty and `irq_o` is low.
- R2: Offset 0x00 is the control register. Bit 0 enables generation and reads back. Writing 0 halts the bit source and word assembly, and queued words stay in the FIFO.
- R3: Offset 0x04 reads the queued word count in bits [31:24], with bits [23:0] reading zero.
- R4: A write to offset 0x04 loads bits [23:0] as the warm-up count and clears any partly built word. While the count is nonzero, each generated bit is discarded and decrements the count by one.
- R5: The bit source is a 32-bit shift register seeded with 0xACE12468 at reset. Each generated bit is state[31]. The state then shifts left with the XOR of bits 31, 21, 1 and 0 entering at bit 0. After warm-up, each run of 32 bits forms a word whose first bit is the MSB.
- R6: A read of offset 0x08 returns the oldest queued word and removes it, lowering the count by one.
- R7: A read of offset 0x08 with the FIFO empty returns zero and leaves the count unchanged.
- R8: The FIFO holds 16 words. When it is full and warm-up is over, the bit source and word assembly pause, so no bit is skipped.
- R9: Offset 0x10 bit 0 is the interrupt mask and reads back. `irq_o` is high exactly when the count is nonzero, generation is enabled and the mask is clear.
- R10: Reads of unmapped offsets return zero, and writes to them or to offset 0x08 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when no read is active |
| irq_o | output | 1 | Words-available interrupt |

## Verification
The assertions take it for granted that the bus inputs are steady across each rising edge and that there is at most one access per cycle. They also assume nothing drives the FIFO except the block's own gating. The bench changes the inputs only on falling edges, one access per cycle, and idles with the strobe low. It uses small warm-up counts so that fills, drains, empty reads and stalls all fall inside the run.

// File: rtl/rng_periph_pkg.sv
package rng_periph_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h08;
  localparam logic [7:0] OFS_MASK = 8'h10;

  typedef enum logic [2:0] {
    REG_CTRL,
    REG_STAT,
    REG_DATA,
    REG_MASK,
    REG_NONE
  } reg_sel_e;
endpackage

// File: rtl/rng_lfsr_src.sv
module rng_lfsr_src #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] SEED = 32'hACE1_2468,
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic bit_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else if (step_i) state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign bit_o = state_q[W-1];

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/rng_word_packer.sv
module rng_word_packer #(
  parameter int unsigned W      = 32,
  parameter int unsigned WARM_W = 24,
  localparam int unsigned BC_W  = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              bit_i,
  input  logic              load_i,
  input  logic [WARM_W-1:0] load_val_i,
  output logic              warm_done_o,
  output logic              push_o,
  output logic [W-1:0]      word_o
);
  logic [WARM_W-1:0] warm_q;
  logic [BC_W-1:0]   bcnt_q;
  logic [W-1:0]      shreg_q;
  logic              last_bit;

  assign warm_done_o = (warm_q == '0);
  assign last_bit    = (bcnt_q == BC_W'(W-1));
  assign word_o      = {shreg_q[W-2:0], bit_i};
  assign push_o      = step_i && warm_done_o && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
    end else if (load_i) begin
      warm_q  <= load_val_i;
      bcnt_q  <= '0;
      shreg_q <= '0;
    end else if (step_i) begin
      if (!warm_done_o) begin
        warm_q <= warm_q - 1'b1;
      end else begin
        shreg_q <= word_o;
        bcnt_q  <= last_bit ? '0 : bcnt_q + 1'b1;
      end
    end
  end

  // R4
  warm_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != '0) |-> !push_o);
  // R4
  warm_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && warm_q != '0) |=> (warm_q == $past(warm_q) - 1'b1));
endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o && !pop_i));
  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o));
  // R6
  pop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rng_periph.sv
module rng_periph
  import rng_periph_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned WARM_W     = 24,
  parameter logic [31:0] SEED       = 32'hACE1_2468,
  localparam int unsigned WORD_W    = 32,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  reg_sel_e          rsel;
  logic              en_q, mask_q;
  logic              rd_acc, wr_acc;
  logic              step, src_bit, warm_done, push, pop, full, empty;
  logic [WORD_W-1:0] word, head;
  logic [CNT_W-1:0]  count;
  logic [7:0]        count8;

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rsel = REG_CTRL;
      OFS_STAT: rsel = REG_STAT;
      OFS_DATA: rsel = REG_DATA;
      OFS_MASK: rsel = REG_MASK;
      default:  rsel = REG_NONE;
    endcase
  end

  assign rd_acc = sel_i && !we_i;
  assign wr_acc = sel_i && we_i;
  assign pop    = rd_acc && (rsel == REG_DATA) && !empty;
  // stall only once warm-up is over, so discarded bits never wait on the FIFO
  assign step   = en_q && !(warm_done && full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_acc) begin
      if (rsel == REG_CTRL) en_q   <= wdata_i[0];
      if (rsel == REG_MASK) mask_q <= wdata_i[0];
    end
  end

  rng_lfsr_src #(.W(WORD_W), .SEED(SEED)) u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .bit_o (src_bit)
  );

  rng_word_packer #(.W(WORD_W), .WARM_W(WARM_W)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .bit_i      (src_bit),
    .load_i     (wr_acc && rsel == REG_STAT),
    .load_val_i (wdata_i[WARM_W-1:0]),
    .warm_done_o(warm_done),
    .push_o     (push),
    .word_o     (word)
  );

  rng_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .data_i (word),
    .pop_i  (pop),
    .data_o (head),
    .count_o(count),
    .full_o (full),
    .empty_o(empty)
  );

  assign count8 = 8'(count);

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      unique case (rsel)
        REG_CTRL: rdata_o = {31'b0, en_q};
        REG_STAT: rdata_o = {count8, 24'b0};
        REG_DATA: rdata_o = empty ? '0 : head;
        REG_MASK: rdata_o = {31'b0, mask_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = en_q && !mask_q && !empty;

  // R7
  empty_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && rsel == REG_DATA && count == '0) |-> (rdata_o == '0));
  // R2
  halt_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !push);
  // R9
  mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q || count == '0) |-> !irq_o);
endmodule

// File: tb/rng_periph_tb_top.sv
module rng_periph_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_lfsr = 32'hACE1_2468;
  int unsigned m_warm = 0;
  logic [31:0] m_word = '0;
  int          m_bits = 0;
  logic [31:0] m_q[$];
  bit          m_en = 0, m_mask = 0;

  always #2 clk = ~clk;

  rng_periph dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] m_read(bit s, bit w, logic [7:0] a);
    if (!s || w) return '0;
    case (a)
      8'h00: return {31'b0, m_en};
      8'h04: return {8'(m_q.size()), 24'b0};
      8'h08: return (m_q.size() == 0) ? '0 : m_q[0];
      8'h10: return {31'b0, m_mask};
      default: return '0;
    endcase
  endfunction

  function automatic void m_update(bit s, bit w, logic [7:0] a, logic [31:0] d);
    bit b;
    bit gen = m_en && !(m_warm == 0 && m_q.size() == 16);
    if (s && !w && a == 8'h08 && m_q.size() > 0) void'(m_q.pop_front());
    if (gen) begin
      b = m_lfsr[31];
      m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
      if (m_warm != 0) m_warm--;
      else begin
        m_word = {m_word[30:0], b};
        m_bits++;
        if (m_bits == 32) begin
          m_q.push_back(m_word);
          m_bits = 0;
        end
      end
    end
    if (s && w) begin
      case (a)
        8'h00: m_en = d[0];
        8'h04: begin m_warm = d[23:0]; m_bits = 0; m_word = '0; end
        8'h10: m_mask = d[0];
        default: ;
      endcase
    end
  endfunction

  function automatic void check(logic [31:0] act, logic [31:0] exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endfunction

  task automatic step(bit s, bit w, logic [7:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d;
    #1;
    check(rdata, m_read(s, w, a), tag);
    check({31'b0, irq}, {31'b0, (m_en && !m_mask && m_q.size() > 0)}, "R9 irq");
    @(posedge clk);
    m_update(s, w, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, '0, "R2 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(1, 0, 8'h00, '0, "R1 ctrl");
    step(1, 0, 8'h04, '0, "R1 stat");
    step(1, 0, 8'h08, '0, "R1 data");
    step(1, 0, 8'h10, '0, "R1 mask");
    // R10 unmapped reads and writes
    step(1, 0, 8'h0C, '0, "R10 rd 0C");
    step(1, 1, 8'h14, 32'hFFFF_FFFF, "R10 wr 14");
    step(1, 1, 8'h08, 32'hFFFF_FFFF, "R10 wr data");
    step(1, 0, 8'h14, '0, "R10 rd 14");
    // R4 warm-up then R2 enable
    step(1, 1, 8'h04, 32'hFF00_0007, "R4 load");
    step(1, 1, 8'h00, 32'h1, "R2 enable");
    step(1, 0, 8'h00, '0, "R2 ctrl rb");
    for (int i = 0; i < 80 && m_q.size() == 0; i++) step(1, 0, 8'h04, '0, "R3 poll");
    check(32'(m_q.size()), 32'd1, "R4 first word after warm-up");
    step(1, 0, 8'h08, '0, "R5 first word");
    step(1, 0, 8'h04, '0, "R6 count after pop");
    // R8 fill and stall
    idle(700);
    step(1, 0, 8'h04, '0, "R8 full count");
    idle(50);
    for (int i = 0; i < 16; i++) step(1, 0, 8'h08, '0, "R8 drain no loss");
    // R9 mask
    idle(40);
    step(1, 1, 8'h10, 32'h1, "R9 mask set");
    step(1, 0, 8'h10, '0, "R9 mask rb");
    idle(5);
    step(1, 1, 8'h10, 32'h0, "R9 mask clr");
    // R2 halt keeps queue
    step(1, 1, 8'h00, 32'h0, "R2 halt");
    idle(100);
    step(1, 0, 8'h04, '0, "R2 count held");
    // R7 drain then empty reads
    for (int i = 0; i < 20; i++) step(1, 0, 8'h08, '0, "R7 drain/empty");
    step(1, 0, 8'h04, '0, "R7 count zero");
    // R4 mid-word reload while running
    step(1, 1, 8'h00, 32'h1, "R2 re-enable");
    idle(45);
    step(1, 1, 8'h04, 32'd100, "R4 reload mid-word");
    idle(300);
    for (int i = 0; i < 6; i++) step(1, 0, 8'h08, '0, "R6 pop after reload");
    // R8 pop while full and pushing
    idle(600);
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 8'h08, '0, "R8 pop at full");
      idle(31);
    end
    step(1, 0, 8'h04, '0, "R3 final count");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule